// File: doc/BRIEF.md
# Receive Packet Byte Buffer with Error Rollback

This block buffers the bytes a receive packet handler produces until a host reads them. Storage is a circular buffer of `DEPTH` bytes (64 by default) addressed by a write pointer, a read pointer and a packet base pointer. The packet handler frames each packet with a start strobe and an end strobe. The end strobe carries a good/bad verdict from the CRC and header checks, which are computed elsewhere. A good verdict makes the packet's bytes visible to the host. A bad verdict moves the write pointer back to the packet base, so the failed packet leaves no trace.

With the multi-packet mode bit set, good packets accumulate one after another. With it clear, every packet start empties the buffer, so at most one packet is ever held. When the length field is variable, the block stores the packet's length byte ahead of the payload as the packet opens. A 6-bit threshold drives an almost-full flag. Writing into a full buffer and reading from an empty one each set a sticky error flag, and a synchronous clear input restores the reset state.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, `fill_level` and `rd_avail` are 0, `empty` is 1, `full`, `overflow` and `underflow` are 0, and `rd_data` is 0.
- R2: A read (`rd_en` high) of a non-empty buffer presents the oldest readable byte on `rd_data` from the clock edge that takes the read, and bytes come out in the order they were written.
- R3: A byte offered while `fill_level` equals `DEPTH` is dropped and `overflow` is set; `overflow` stays set until reset or `clr`.
- R4: A read while `rd_avail` is 0 returns 0 on `rd_data`, leaves the pointers unchanged and sets a sticky `underflow`.
- R5: Only bytes of packets that ended with `pkt_ok` = 1 count in `rd_avail` and can be read; bytes of the open packet count only in `fill_level`.
- R6: `pkt_end` with `pkt_ok` = 0 returns `fill_level` to the number of readable bytes, discarding every byte of that packet.
- R7: With `multi_en` = 1, successive good packets are kept back to back and read out in arrival order.
- R8: With `multi_en` = 0, `pkt_start` empties the buffer, including unread bytes of earlier packets.
- R9: With `fixed_len` = 0, `pkt_start` stores `pkt_len` as the first byte of the packet; with `fixed_len` = 1 it stores nothing.
- R10: `almost_full` is 1 exactly when `fill_level` is greater than or equal to `af_thr`.
- R11: `wr_en` is ignored in a cycle with `pkt_start` or `pkt_end` high. A `pkt_start` while a packet is open discards the open packet's bytes.
- R12: Pointers wrap modulo `DEPTH`, so byte order and counts stay correct across many packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of pointers, flags and read data |
| multi_en | input | 1 | 1: keep several packets; 0: each packet start empties the buffer |
| fixed_len | input | 1 | 1: no length byte stored; 0: length byte stored at packet start |
| af_thr | input | AW (6) | Almost-full threshold |
| pkt_start | input | 1 | Packet start strobe |
| pkt_len | input | 8 | Length byte stored with the start strobe when `fixed_len` is 0 |
| pkt_end | input | 1 | Packet end strobe |
| pkt_ok | input | 1 | Verdict with `pkt_end`: 1 good, 0 CRC or header error |
| wr_en | input | 1 | Payload byte valid |
| wr_data | input | 8 | Payload byte |
| rd_en | input | 1 | Host read request |
| rd_data | output | 8 | Registered read byte |
| fill_level | output | AW+1 (7) | Bytes stored, including the open packet |
| rd_avail | output | AW+1 (7) | Bytes readable by the host |
| empty | output | 1 | No readable byte |
| full | output | 1 | `fill_level` equals `DEPTH` |
| almost_full | output | 1 | `fill_level` at or above `af_thr` |
| overflow | output | 1 | Sticky: a byte was dropped on a full buffer |
| underflow | output | 1 | Sticky: a read found no readable byte |

## Verification
The main function is exercised with the following traffic:
- Runs of good packets with and without length bytes, which separate correct ordering from lost or duplicated bytes.
- Good/bad packet pairs, which separate a correct rollback from one that lands on the wrong pointer.
- Host reads while a packet is still open, which show whether uncommitted bytes leak to the host.
- Restarts of an open packet and single-packet restarts over unread data, which distinguish the two retention modes.
- A long run of mixed-verdict packets of varying length with reads in between, which drives the pointers through several wraps.
- Strobes that coincide with data bytes and a burst past capacity, which probe the dropped-byte rules and the threshold flag at each fill level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    byte_t cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    input  logic [PW-1:0] base_ptr,
    input  logic [AW-1:0] thr,
    output logic [PW-1:0] level,
    output logic [PW-1:0] avail,
    output logic          empty,
    output logic          full,
    output logic          af
);
    always_comb begin
        level = wr_ptr - rd_ptr;
        avail = base_ptr - rd_ptr;
        empty = (avail == '0);
        full  = (level == PW'(DEPTH));
        af    = (level >= {1'b0, thr});
    end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          multi_en,
    input  logic          fixed_len,
    input  logic          pkt_start,
    input  byte_t         pkt_len,
    input  logic          pkt_end,
    input  logic          pkt_ok,
    input  logic          wr_en,
    input  byte_t         wr_data,
    input  logic          rd_en,
    input  logic          empty,
    input  byte_t         mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output byte_t         mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] base_ptr,
    output logic          ovf,
    output logic          unf,
    output byte_t         rd_data
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW-1:0] base;
        logic          ovf;
        logic          unf;
        byte_t         rdata;
    } st_t;

    st_t           st_d, st_q;
    logic [PW-1:0] w_nx;
    logic [PW-1:0] r_ref;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_waddr = st_q.wr[AW-1:0];
        mem_wdata = wr_data;
        mem_raddr = st_q.rd[AW-1:0];
        w_nx      = st_q.wr;
        r_ref     = st_q.rd;

        // host side: registered read of the oldest committed byte
        if (rd_en) begin
            if (empty) begin
                st_d.unf   = 1'b1;
                st_d.rdata = '0;
            end else begin
                st_d.rdata = mem_rdata;
                st_d.rd    = st_q.rd + 1'b1;
            end
        end

        // packet side: start, end, or payload byte
        if (pkt_start) begin
            if (!multi_en) begin
                w_nx    = '0;
                r_ref   = '0;
                st_d.rd = '0;
            end else begin
                w_nx = st_q.base;
            end
            st_d.base = w_nx;
            if (!fixed_len) begin
                if ((w_nx - r_ref) == PW'(DEPTH)) begin
                    st_d.ovf = 1'b1;
                end else begin
                    mem_we    = 1'b1;
                    mem_waddr = w_nx[AW-1:0];
                    mem_wdata = pkt_len;
                    w_nx      = w_nx + 1'b1;
                end
            end
        end else if (pkt_end) begin
            if (pkt_ok) begin
                st_d.base = st_q.wr;
            end else begin
                w_nx = st_q.base;
            end
        end else if (wr_en) begin
            if ((w_nx - r_ref) == PW'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                mem_we    = 1'b1;
                mem_waddr = w_nx[AW-1:0];
                mem_wdata = wr_data;
                w_nx      = w_nx + 1'b1;
            end
        end
        st_d.wr = w_nx;

        if (clr) begin
            st_d   = '0;
            mem_we = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr   = st_q.wr;
    assign rd_ptr   = st_q.rd;
    assign base_ptr = st_q.base;
    assign ovf      = st_q.ovf;
    assign unf      = st_q.unf;
    assign rd_data  = st_q.rdata;

    // the read pointer never passes the commit point (R5)
    p_rd_within_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ptr - rd_ptr) <= (wr_ptr - rd_ptr));

    // a rejected read leaves the read pointer where it was (R4)
    p_unf_keeps_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !clr && !(pkt_start && !multi_en)) |=> $stable(rd_ptr));
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
    import rxf_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          multi_en,
    input  logic          fixed_len,
    input  logic [AW-1:0] af_thr,
    input  logic          pkt_start,
    input  logic [7:0]    pkt_len,
    input  logic          pkt_end,
    input  logic          pkt_ok,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic [PW-1:0] fill_level,
    output logic [PW-1:0] rd_avail,
    output logic          empty,
    output logic          full,
    output logic          almost_full,
    output logic          overflow,
    output logic          underflow
);
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    byte_t         mem_wdata;
    byte_t         mem_rdata;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] base_ptr;

    rxf_store #(.DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    rxf_flags #(.DEPTH(DEPTH)) i_flags (
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .base_ptr (base_ptr),
        .thr      (af_thr),
        .level    (fill_level),
        .avail    (rd_avail),
        .empty    (empty),
        .full     (full),
        .af       (almost_full)
    );

    rxf_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .multi_en  (multi_en),
        .fixed_len (fixed_len),
        .pkt_start (pkt_start),
        .pkt_len   (pkt_len),
        .pkt_end   (pkt_end),
        .pkt_ok    (pkt_ok),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .empty     (empty),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .base_ptr  (base_ptr),
        .ovf       (overflow),
        .unf       (underflow),
        .rd_data   (rd_data)
    );

    p_clear_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill_level == '0 && !overflow && !underflow && rd_data == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !pkt_start && !pkt_end && !clr) |=> overflow);

    p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow);

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !clr) |=> (underflow && rd_data == '0));

    p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && pkt_ok && !rd_en && !clr) |=> (rd_avail == $past(fill_level)));

    p_rollback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !pkt_ok && !rd_en && !clr) |=> (fill_level == $past(rd_avail)));

    p_single_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !multi_en && fixed_len && !clr) |=> (fill_level == '0));
endmodule

// File: tb/test_rx_pkt_fifo.sv
module test_rx_pkt_fifo;
    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int PW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          multi_en = 1'b1;
    logic          fixed_len = 1'b0;
    logic [AW-1:0] af_thr = '1;
    logic          pkt_start = 1'b0;
    logic [7:0]    pkt_len = '0;
    logic          pkt_end = 1'b0;
    logic          pkt_ok = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [PW-1:0] fill_level;
    logic [PW-1:0] rd_avail;
    logic          empty, full, almost_full, overflow, underflow;

    always #2.5 clk = ~clk;

    rx_pkt_fifo #(.DEPTH(DEPTH)) i_rx_pkt_fifo (
        .clk(clk), .rst_n(rst_n), .clr(clr), .multi_en(multi_en),
        .fixed_len(fixed_len), .af_thr(af_thr), .pkt_start(pkt_start),
        .pkt_len(pkt_len), .pkt_end(pkt_end), .pkt_ok(pkt_ok),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .fill_level(fill_level), .rd_avail(rd_avail), .empty(empty),
        .full(full), .almost_full(almost_full), .overflow(overflow),
        .underflow(underflow)
    );

    // behavioural reference: readable bytes and open-packet bytes as queues
    logic [7:0] m_ready[$];
    logic [7:0] m_open[$];
    logic       m_ovf, m_unf;
    logic [7:0] m_rdata;
    int         checks = 0;
    int         fails  = 0;
    string      cur_req = "R1";

    task automatic model_reset();
        m_ready.delete();
        m_open.delete();
        m_ovf = 1'b0;
        m_unf = 1'b0;
        m_rdata = '0;
    endtask

    task automatic model_step();
        int total;
        if (!rst_n || clr) begin
            model_reset();
            return;
        end
        total = m_ready.size() + m_open.size();
        if (rd_en) begin
            if (m_ready.size() == 0) begin
                m_unf = 1'b1;
                m_rdata = '0;
            end else begin
                m_rdata = m_ready.pop_front();
            end
        end
        if (pkt_start) begin
            if (!multi_en) begin
                m_ready.delete();
                total = 0;
            end else begin
                total = total - m_open.size();
            end
            m_open.delete();
            if (!fixed_len) begin
                if (total == DEPTH) m_ovf = 1'b1;
                else m_open.push_back(pkt_len);
            end
        end else if (pkt_end) begin
            if (pkt_ok) begin
                foreach (m_open[i]) m_ready.push_back(m_open[i]);
            end
            m_open.delete();
        end else if (wr_en) begin
            if (total == DEPTH) m_ovf = 1'b1;
            else m_open.push_back(wr_data);
        end
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int lvl;
        lvl = m_ready.size() + m_open.size();
        chk(rd_data == m_rdata, "rd_data", rd_data, m_rdata);
        chk(fill_level == PW'(lvl), "fill_level", fill_level, lvl);
        chk(rd_avail == PW'(m_ready.size()), "rd_avail", rd_avail, m_ready.size());
        chk(empty == (m_ready.size() == 0), "empty", empty, m_ready.size() == 0);
        chk(full == (lvl == DEPTH), "full", full, lvl == DEPTH);
        chk(almost_full == (lvl >= int'(af_thr)), "almost_full", almost_full, lvl >= int'(af_thr));
        chk(overflow == m_ovf, "overflow", overflow, m_ovf);
        chk(underflow == m_unf, "underflow", underflow, m_unf);
    endtask

    task automatic tick(input logic s, input logic [7:0] ln, input logic e, input logic ok,
                        input logic w, input logic [7:0] wd, input logic r);
        pkt_start = s; pkt_len = ln; pkt_end = e; pkt_ok = ok;
        wr_en = w; wr_data = wd; rd_en = r;
        @(posedge clk);
        #1;
        model_step();
        compare();
    endtask

    task automatic idle();
        tick(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_clr();
        clr = 1'b1;
        idle();
        clr = 1'b0;
    endtask

    task automatic send_pkt(input int n, input bit good, input logic [7:0] seed);
        tick(1, 8'(n), 0, 0, 0, 0, 0);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 1, seed + 8'(i), 0);
        tick(0, 0, 1, good, 0, 0, 0);
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cur_req = "R1";
        idle();

        // R9 and R7: variable length, two good packets kept back to back
        cur_req = "R9";
        send_pkt(3, 1, 8'h10);
        cur_req = "R7";
        send_pkt(5, 1, 8'h20);
        read_n(10);

        // R2: fixed length, in-order readout
        cur_req = "R2";
        fixed_len = 1'b1;
        send_pkt(4, 1, 8'h30);
        read_n(4);

        // R5 and R4: the open packet is not readable
        cur_req = "R5";
        tick(1, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 1, 8'h41, 0);
        tick(0, 0, 0, 0, 1, 8'h42, 0);
        cur_req = "R4";
        tick(0, 0, 0, 0, 0, 0, 1);
        cur_req = "R5";
        tick(0, 0, 1, 1, 0, 0, 0);
        read_n(2);

        // R6: a bad packet after a good one is rolled back
        cur_req = "R6";
        fixed_len = 1'b0;
        send_pkt(3, 1, 8'h50);
        send_pkt(4, 0, 8'h60);
        read_n(5);

        // R11: data with strobes is dropped; restart discards the open packet
        cur_req = "R11";
        tick(1, 8'd9, 0, 0, 1, 8'hA0, 0);
        tick(0, 0, 0, 0, 1, 8'hA1, 0);
        tick(1, 8'd2, 0, 0, 1, 8'hA2, 0);
        tick(0, 0, 0, 0, 1, 8'hA3, 0);
        tick(0, 0, 1, 1, 1, 8'hA4, 0);
        read_n(3);

        // R8: single-packet mode empties earlier unread data
        cur_req = "R8";
        multi_en = 1'b0;
        send_pkt(3, 1, 8'h70);
        send_pkt(2, 1, 8'h80);
        fixed_len = 1'b1;
        tick(1, 0, 0, 0, 0, 0, 1);
        idle();
        multi_en = 1'b1;

        // R3: write past capacity
        cur_req = "R3";
        do_clr();
        tick(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 70; i++) tick(0, 0, 0, 0, 1, 8'(i), 0);
        tick(0, 0, 1, 1, 0, 0, 0);
        read_n(64);
        cur_req = "R4";
        read_n(2);

        // R1: clear drops flags and data
        cur_req = "R1";
        do_clr();

        // R10: threshold flag at each fill level
        cur_req = "R10";
        af_thr = 6'd10;
        tick(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) tick(0, 0, 0, 0, 1, 8'(i), 0);
        tick(0, 0, 0, 1, 0, 0, 0);
        af_thr = 6'd0;
        do_clr();
        idle();
        af_thr = 6'd63;
        idle();

        // R12: many packets of mixed verdicts wrap the pointers
        cur_req = "R12";
        fixed_len = 1'b0;
        for (int k = 0; k < 40; k++) begin
            send_pkt(1 + (k % 7), (k % 3) != 2, 8'(k * 11));
            if (k % 2 == 1) read_n(9);
        end
        read_n(20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule